// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Window Decoder

This block sits beside a host memory-cycle front end. For every memory request it decides whether the 32-bit address lands in one of the firmware windows that are forwarded to an attached serial flash. If so, it reports which window was hit, the byte offset into the flash, and whether the cycle may proceed. Reads that hit an enabled window are always allowed. Writes are allowed only when a separate write gate is open.

A single 8-bit control register selects which windows decode. It also holds a global suspend, the write gate and the choice of which of two physical pins carries the flash chip select. The decoder compares the address against four fixed ranges, each through its own comparator. A priority encoder then resolves the result. The response is registered, so it appears one clock after the request. The mapped flash span never exceeds 512 KiB, so the offset is 19 bits wide.

Top module: `fsw_window_decode`

## Requirements
- R1: After reset the control register reads 0x00, `rsp_valid`, `rsp_hit` and `rsp_allow` are 0, and `cs_pin_sel` is 0.
- R2: While control bit 0 (suspend) is 1, no address produces `rsp_hit`, whatever the other bits are.
- R3: Control bit 1 enables two windows: 0xFFFE0000–0xFFFFFFFF (reported as window 0) and 0x000E0000–0x000FFFFF (reported as window 3).
- R4: Control bit 2 enables window 2, 0xFFEE0000–0xFFEFFFFF.
- R5: Control bit 3 enables window 1, 0xFFF80000–0xFFFEFFFF.
- R6: `rsp_allow` is 1 exactly when the response is a hit and either the request was a read or control bit 4 (write gate) is 1.
- R7: On a hit, `rsp_offset` equals address bits 18:0. As a result, the legacy window 0x000E0000 maps onto the same offsets as 0xFFFE0000.
- R8: `rsp_valid` and the decode fields appear one clock after `req_valid`. With `req_valid` low the next response has `rsp_valid` = 0 and `rsp_hit` = 0.
- R9: `cs_pin_sel` equals control bit 5 from the clock after the register is written.
- R10: Control bits 7:6 are reserved: writes to them are ignored, and they read back as 0.
- R11: When several enabled windows match, the lowest window number wins. Window numbers are ordered from the top of the address space downward, with 0 the highest and the legacy window last.
- R12: On a miss, `rsp_offset`, `rsp_win` and `rsp_allow` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| ctrl_q | output | 8 | Control register contents |
| cs_pin_sel | output | 1 | Chip-select pin choice (control bit 5) |
| req_valid | input | 1 | Memory request present this cycle |
| req_addr | input | 32 | Memory request address |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| rsp_valid | output | 1 | Registered response valid |
| rsp_hit | output | 1 | Address hit an enabled window |
| rsp_allow | output | 1 | Cycle may be forwarded to the flash |
| rsp_win | output | 2 | Index of the winning window |
| rsp_offset | output | 19 | Byte offset into the flash |

## Verification
The decode is hardest to exercise at the window edges, where an address one byte outside a window lands in a neighbouring window or in a gap. This matters most where the top window meets the window just below it at 0xFFFDFFFF/0xFFFE0000. The bench reaches these cases with a full sweep. It programs every control value from 0 to 255. For each value it presents the first byte, last byte, one-below, one-above and an interior address of every window, each as a read and as a write. Each response is checked against a model built from the listed ranges.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    localparam int ADDR_W  = 32;
    localparam int CTRL_W  = 8;
    localparam int OFS_W   = 19;
    localparam int NUM_WIN = 4;
    localparam int WIN_W   = $clog2(NUM_WIN);

    localparam int BIT_SUSPEND = 0;
    localparam int BIT_WR_GATE = 4;
    localparam int BIT_PIN_SEL = 5;

    localparam logic [CTRL_W-1:0] CTRL_MASK  = 8'h3F;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h00;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             allow;
        logic [WIN_W-1:0] win;
        logic [OFS_W-1:0] ofs;
    } resp_t;

    // Window index 0 is the highest range; the index also sets priority.
    function automatic logic [ADDR_W-1:0] win_lo(input int idx);
        case (idx)
            0:       return 32'hFFFE_0000;
            1:       return 32'hFFF8_0000;
            2:       return 32'hFFEE_0000;
            default: return 32'h000E_0000;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] win_hi(input int idx);
        case (idx)
            0:       return 32'hFFFF_FFFF;
            1:       return 32'hFFFE_FFFF;
            2:       return 32'hFFEF_FFFF;
            default: return 32'h000F_FFFF;
        endcase
    endfunction

    function automatic int win_en_bit(input int idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            2:       return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/fsw_ctrl_reg.sv
module fsw_ctrl_reg
    import fsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q
);

    logic [CTRL_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = wdata & CTRL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/fsw_win_match.sv
module fsw_win_match #(
    parameter int                AW = 32,
    parameter logic [AW-1:0]     LO = '0,
    parameter logic [AW-1:0]     HI = '1
) (
    input  logic [AW-1:0] addr,
    input  logic          enable,
    output logic          match
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (addr >= LO);
        below_hi = (addr <= HI);
        match    = enable & above_lo & below_hi;
    end

endmodule

// File: rtl/fsw_prio.sv
module fsw_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  match,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/fsw_window_decode.sv
module fsw_window_decode
    import fsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              cs_pin_sel,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_allow,
    output logic [WIN_W-1:0]  rsp_win,
    output logic [OFS_W-1:0]  rsp_offset
);

    logic [NUM_WIN-1:0] win_en;
    logic [NUM_WIN-1:0] win_match;
    logic               any_match;
    logic [WIN_W-1:0]   win_idx;
    resp_t              rsp_d;
    resp_t              rsp_q;

    fsw_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wdata  (cfg_wdata),
        .ctrl_q (ctrl_q)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign win_en[g] = ctrl_q[win_en_bit(g)] & ~ctrl_q[BIT_SUSPEND];

        fsw_win_match #(
            .AW (ADDR_W),
            .LO (win_lo(g)),
            .HI (win_hi(g))
        ) u_match (
            .addr   (req_addr),
            .enable (win_en[g]),
            .match  (win_match[g])
        );
    end

    fsw_prio #(
        .N  (NUM_WIN),
        .IW (WIN_W)
    ) u_prio (
        .match (win_match),
        .any   (any_match),
        .idx   (win_idx)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid && any_match) begin
            rsp_d.hit   = 1'b1;
            rsp_d.win   = win_idx;
            rsp_d.ofs   = req_addr[OFS_W-1:0];
            rsp_d.allow = ~req_write | ctrl_q[BIT_WR_GATE];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_allow  = rsp_q.allow;
    assign rsp_win    = rsp_q.win;
    assign rsp_offset = rsp_q.ofs;
    assign cs_pin_sel = ctrl_q[BIT_PIN_SEL];

endmodule

// File: rtl/fsw_window_decode_chk.sv
module fsw_window_decode_chk
    import fsw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              req_valid,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_allow,
    input logic [WIN_W-1:0]  rsp_win,
    input logic [OFS_W-1:0]  rsp_offset
);

    assert_suspend_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(!ctrl_q[BIT_SUSPEND]));

    assert_allow_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> rsp_hit);

    assert_write_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_allow && $past(req_write)) |-> $past(ctrl_q[BIT_WR_GATE]));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7:6] == 2'b00);

    assert_miss_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_offset == '0 && rsp_win == '0 && !rsp_allow));

endmodule

bind fsw_window_decode fsw_window_decode_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_q     (ctrl_q),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_allow  (rsp_allow),
    .rsp_win    (rsp_win),
    .rsp_offset (rsp_offset)
);

// File: tb/sim_fsw_window_decode.sv
module sim_fsw_window_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  ctrl_q;
    logic        cs_pin_sel;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_allow;
    logic [1:0]  rsp_win;
    logic [18:0] rsp_offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fsw_window_decode u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .ctrl_q     (ctrl_q),
        .cs_pin_sel (cs_pin_sel),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_allow  (rsp_allow),
        .rsp_win    (rsp_win),
        .rsp_offset (rsp_offset)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Window ranges, indices and enable bits taken from the requirements (R3, R4, R5, R11).
    function automatic logic [31:0] lo_of(input int i);
        case (i)
            0: return 32'hFFFE_0000;
            1: return 32'hFFF8_0000;
            2: return 32'hFFEE_0000;
            default: return 32'h000E_0000;
        endcase
    endfunction

    function automatic logic [31:0] hi_of(input int i);
        case (i)
            0: return 32'hFFFF_FFFF;
            1: return 32'hFFFE_FFFF;
            2: return 32'hFFEF_FFFF;
            default: return 32'h000F_FFFF;
        endcase
    endfunction

    function automatic int en_of(input int i);
        case (i)
            0: return 1;
            1: return 3;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        check("R10 readback", {24'h0, ctrl_q}, {24'h0, v & 8'h3F});
        check("R9 pin select", {31'h0, cs_pin_sel}, {31'h0, v[5]});
    endtask

    task automatic probe(input logic [7:0] c, input logic [31:0] a, input logic wr);
        logic e_hit;
        logic e_allow;
        logic [1:0] e_win;
        logic [18:0] e_ofs;
        string tag;
        e_hit = 1'b0;
        e_win = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (!c[0] && c[en_of(i)] && a >= lo_of(i) && a <= hi_of(i)) begin
                e_hit = 1'b1;
                e_win = 2'(i);
            end
        end
        e_ofs   = e_hit ? a[18:0] : 19'h0;
        e_allow = e_hit && (!wr || c[4]);
        if (c[0])                tag = "R2 suspend";
        else if (!e_hit)         tag = "R12 miss";
        else if (e_win == 2'd0 || e_win == 2'd3) tag = "R3 bit1 window";
        else if (e_win == 2'd2)  tag = "R4 bit2 window";
        else                     tag = "R5 bit3 window";
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        @(negedge clk);
        check("R8 valid", {31'h0, rsp_valid}, 32'h1);
        check(tag, {31'h0, rsp_hit}, {31'h0, e_hit});
        check("R11 window index", {30'h0, rsp_win}, {30'h0, e_win});
        check("R7 offset", {13'h0, rsp_offset}, {13'h0, e_ofs});
        check("R6 allow", {31'h0, rsp_allow}, {31'h0, e_allow});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ctrl", {24'h0, ctrl_q}, 32'h0);
        check("R1 valid", {31'h0, rsp_valid}, 32'h0);
        check("R1 hit", {31'h0, rsp_hit}, 32'h0);
        check("R1 allow", {31'h0, rsp_allow}, 32'h0);
        check("R1 pin", {31'h0, cs_pin_sel}, 32'h0);
        rst_n = 1'b1;

        for (int c = 0; c < 256; c++) begin
            write_ctrl(8'(c));
            @(negedge clk);
            for (int w = 0; w < 4; w++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [31:0] a;
                    case (k)
                        0: a = lo_of(w) - 32'd1;
                        1: a = lo_of(w);
                        2: a = lo_of(w) + 32'h1234;
                        3: a = hi_of(w);
                        default: a = hi_of(w) + 32'd1;
                    endcase
                    probe(8'(c) & 8'h3F, a, 1'b0);
                    probe(8'(c) & 8'h3F, a, 1'b1);
                end
            end
            req_valid = 1'b0;
            req_addr  = 32'hFFFF_0000;
            @(negedge clk);
            check("R8 idle valid", {31'h0, rsp_valid}, 32'h0);
            check("R8 idle hit", {31'h0, rsp_hit}, 32'h0);
        end

        // Legacy and top windows share offsets (R7).
        write_ctrl(8'h12);
        @(negedge clk);
        probe(8'h12, 32'h000E_4321, 1'b0);
        check("R7 legacy offset", {13'h0, rsp_offset}, 32'h0006_4321);
        probe(8'h12, 32'hFFFE_4321, 1'b0);
        check("R7 top offset", {13'h0, rsp_offset}, 32'h0006_4321);
        req_valid = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule